// File: doc/BRIEF.md
# Write-Through Write-Evict Data Cache Controller

This block is the tag and policy controller of a set-associative data cache. It holds no data; it decides, for each request, what happens to the tag state and what has to go out to memory. A request carries an address, a write flag, a two-bit access class and a requester id. The controller answers in the same cycle with a status code and up to three one-cycle event strobes. Any traffic it generates goes into a bounded miss queue that drains to memory over a valid/ready port.

The write policy depends on the access class. A global write that hits removes the line and forwards the write. A local write, or a write of the writeback class, that hits keeps the line and marks it dirty. A write that misses is forwarded without allocating a line. A read miss reserves a way and sends a full-line read. If the way it displaces is dirty, a line-sized writeback follows the read. While a line is outstanding, further reads to it are merged in a small miss-status table. When the fill port returns the line, the merged requesters are released one per cycle, in the order they arrived.

Top module: `wtwe_dcache`

## Requirements
- R1: `resp_status` encodes HIT=0, HIT_RESERVED=1, MISS=2, RESERVATION_FAIL=3. A read (class 0, write flag low) that finds its line VALID or MODIFIED returns HIT, refreshes LRU, queues nothing and raises no event.
- R2: A write of class 1 (global) that finds its line VALID returns HIT and raises `ev_write_sent`. It invalidates the line, so a later read to that line misses. It queues the request unchanged: kind 1 (write), the original address, the full-line flag low and the request id. A global write must never find its line MODIFIED.
- R3: A write of class 2 (local) or class 3 (writeback) that finds its line VALID or MODIFIED returns HIT. It marks the line MODIFIED and refreshes LRU. It queues nothing and raises no event.
- R4: A write whose line is absent or still RESERVED returns MISS and raises `ev_write_sent`. The write is queued as kind 1 and no line is allocated. A reserved line stays reserved.
- R5: A read miss returns MISS and raises `ev_read_sent`. It reserves a way, choosing an INVALID way first, and queues kind 0 with the line-aligned address and the full-line flag high. A line is never held in two ways of its set.
- R6: When the way chosen on a read miss is MODIFIED, a kind 2 entry with the line address of the evicted line and the full-line flag high is queued directly behind the read, and `ev_wb_sent` is raised. `ev_wb_sent` is never raised without `ev_read_sent`.
- R7: When no way of the set is INVALID, the victim is the least recently used way among those not RESERVED.
- R8: A write that needs a queue slot returns RESERVATION_FAIL while the queue holds MQ_DEPTH entries. A read miss returns RESERVATION_FAIL while the queue holds MQ_DEPTH-1 or more entries, because it may need two slots.
- R9: A read miss also returns RESERVATION_FAIL when every miss-status entry is busy or every way of the set is RESERVED. A read to a RESERVED line returns RESERVATION_FAIL when its merge list already holds MSHR_MERGE ids.
- R10: A request that returns RESERVATION_FAIL raises no event, queues nothing and changes no line state.
- R11: A read that finds its line RESERVED returns HIT_RESERVED, raises no event and appends its id to that line's merge list.
- R12: A fill of a reserved line, accepted while `fill_ready` is high, makes the line VALID. Starting the cycle after the fill, every merged id is presented on `rel_id` with `rel_valid`, one per cycle, in arrival order. `fill_ready` is low during that release.
- R13: The miss queue delivers entries in the order they were pushed. While `mq_valid` is high and `mq_ready` is low, the head entry does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | High for a write |
| req_class | input | 2 | 0 read, 1 global write, 2 local write, 3 writeback |
| req_id | input | ID_W | Requester tag |
| resp_status | output | 2 | Outcome code, valid with req_valid |
| ev_read_sent | output | 1 | Line read queued this cycle |
| ev_write_sent | output | 1 | Write-through queued this cycle |
| ev_wb_sent | output | 1 | Dirty writeback queued this cycle |
| mq_valid | output | 1 | Miss queue head present |
| mq_ready | input | 1 | Memory accepts the head |
| mq_addr | output | ADDR_W | Head address |
| mq_kind | output | 2 | 0 read, 1 write, 2 writeback |
| mq_full_line | output | 1 | Head covers a whole line |
| mq_id | output | ID_W | Head requester tag |
| fill_valid | input | 1 | Line returned from memory |
| fill_line | input | ADDR_W-OFF_W | Line address of the fill |
| fill_ready | output | 1 | Fill can be accepted |
| rel_valid | output | 1 | A merged requester is released |
| rel_id | output | ID_W | Released requester tag |

## Verification
Wrong line state inside the block shows up at the ports on the next request to that line. A line left VALID after a global write returns HIT where MISS is due. A lost dirty mark drops the kind 2 entry when the line is evicted. A wrong LRU age evicts the other way, and the next read of the survivor misses instead of hitting. Merge-list errors appear during the release that follows the fill, as a missing, extra or reordered `rel_id`. Queue faults appear when the head is popped or sampled while memory stalls.

// File: rtl/wtwe_pkg.sv
// Shared encodings for the write-through write-evict cache controller.
// Assumes: two-bit codes are visible on the top-level ports as plain vectors.
package wtwe_pkg;

    typedef enum logic [1:0] {
        ST_HIT     = 2'd0,
        ST_HIT_RSV = 2'd1,
        ST_MISS    = 2'd2,
        ST_FAIL    = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        CL_READ = 2'd0,
        CL_GWR  = 2'd1,
        CL_LWR  = 2'd2,
        CL_WBK  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        LN_INVALID  = 2'd0,
        LN_RESERVED = 2'd1,
        LN_VALID    = 2'd2,
        LN_MODIFIED = 2'd3
    } line_e;

    typedef enum logic [1:0] {
        MQ_RD = 2'd0,
        MQ_WR = 2'd1,
        MQ_WB = 2'd2
    } mqk_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_TOUCH   = 3'd1,
        OP_DIRTY   = 3'd2,
        OP_INVAL   = 3'd3,
        OP_RESERVE = 3'd4
    } tagop_e;

endpackage

// File: rtl/wtwe_tags.sv
// Tag and line-state store with age-based LRU for each set.
// Does: lookup, victim choice (INVALID first, else oldest non-RESERVED way),
// one state update per cycle on the looked-up set, and fill completion.
// Assumes: WAYS >= 2; the update way never equals the fill way.
module wtwe_tags
    import wtwe_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_idx,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    output logic [$clog2(WAYS)-1:0]  lk_way,
    output line_e                    lk_state,
    output logic                     vic_ok,
    output logic [$clog2(WAYS)-1:0]  vic_way,
    output line_e                    vic_state,
    output logic [TAG_W-1:0]         vic_tag,
    input  tagop_e                   op,
    input  logic [$clog2(WAYS)-1:0]  op_way,
    input  logic                     fill_en,
    input  logic [$clog2(SETS)-1:0]  fill_idx,
    input  logic [TAG_W-1:0]         fill_tag
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;

    line_e            st  [SETS][WAYS];
    logic [TAG_W-1:0] tg  [SETS][WAYS];
    logic [AGE_W-1:0] age [SETS][WAYS];

    logic [WAYS-1:0]  hit_vec;
    logic             fill_hit;
    logic [WAY_W-1:0] fill_way;
    logic [AGE_W-1:0] best_age;
    logic             found_inv;

    // Lookup: find the way that holds the requested tag.
    always_comb begin
        lk_hit   = 1'b0;
        lk_way   = '0;
        hit_vec  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st[lk_idx][w] != LN_INVALID && tg[lk_idx][w] == lk_tag) begin
                lk_hit     = 1'b1;
                lk_way     = WAY_W'(w);
                hit_vec[w] = 1'b1;
            end
        end
        lk_state = lk_hit ? st[lk_idx][lk_way] : LN_INVALID;
    end

    // Victim choice: first INVALID way, else the oldest way not RESERVED.
    always_comb begin
        found_inv = 1'b0;
        vic_ok    = 1'b0;
        vic_way   = '0;
        best_age  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st[lk_idx][w] == LN_INVALID && !found_inv) begin
                found_inv = 1'b1;
                vic_ok    = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
        if (!found_inv) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st[lk_idx][w] != LN_RESERVED && (!vic_ok || age[lk_idx][w] >= best_age)) begin
                    vic_ok   = 1'b1;
                    vic_way  = WAY_W'(w);
                    best_age = age[lk_idx][w];
                end
            end
        end
        vic_state = st[lk_idx][vic_way];
        vic_tag   = tg[lk_idx][vic_way];
    end

    // Fill match: the RESERVED way holding the returned tag.
    always_comb begin
        fill_hit = 1'b0;
        fill_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st[fill_idx][w] == LN_RESERVED && tg[fill_idx][w] == fill_tag) begin
                fill_hit = 1'b1;
                fill_way = WAY_W'(w);
            end
        end
    end

    // State, tag and age update for the current request and any fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st[s][w]  <= LN_INVALID;
                    tg[s][w]  <= '0;
                    age[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            if (op == OP_TOUCH || op == OP_DIRTY || op == OP_RESERVE) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) != op_way && age[lk_idx][w] < age[lk_idx][op_way])
                        age[lk_idx][w] <= age[lk_idx][w] + AGE_W'(1);
                end
                age[lk_idx][op_way] <= '0;
            end
            case (op)
                OP_DIRTY:   st[lk_idx][op_way] <= LN_MODIFIED;
                OP_INVAL:   st[lk_idx][op_way] <= LN_INVALID;
                OP_RESERVE: begin
                    st[lk_idx][op_way] <= LN_RESERVED;
                    tg[lk_idx][op_way] <= lk_tag;
                end
                default: ;
            endcase
            if (fill_en && fill_hit)
                st[fill_idx][fill_way] <= LN_VALID;
        end
    end

    // A line address is never present in two ways of one set.
    assert_one_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) <= 1);

endmodule

// File: rtl/wtwe_mshr.sv
// Miss-status table: one entry per outstanding line, each with an ordered
// list of waiting requester ids. A fill starts a release of that list, one
// id per cycle; no further fill is taken until the release ends.
// Assumes: the controller only merges into a matching entry with room.
module wtwe_mshr #(
    parameter int ENT    = 2,
    parameter int MERGE  = 3,
    parameter int LINE_W = 12,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_match,
    output logic              lk_can_merge,
    output logic              free_ok,
    input  logic              alloc_en,
    input  logic              merge_en,
    input  logic [ID_W-1:0]   req_id,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    output logic              fill_ready,
    output logic              rel_valid,
    output logic [ID_W-1:0]   rel_id
);
    localparam int E_W   = (ENT > 1) ? $clog2(ENT) : 1;
    localparam int CNT_W = $clog2(MERGE + 1);
    localparam int POS_W = (MERGE > 1) ? $clog2(MERGE) : 1;

    logic              vld  [ENT];
    logic [LINE_W-1:0] line [ENT];
    logic [CNT_W-1:0]  cnt  [ENT];
    logic [ID_W-1:0]   ids  [ENT][MERGE];

    logic              draining;
    logic [E_W-1:0]    drain_ent;
    logic [POS_W-1:0]  pos;
    logic [E_W-1:0]    m_idx, f_idx, fm_idx;
    logic              fm;

    // Entry search for merge, allocation and fill.
    always_comb begin
        lk_match = 1'b0;
        m_idx    = '0;
        free_ok  = 1'b0;
        f_idx    = '0;
        fm       = 1'b0;
        fm_idx   = '0;
        for (int e = 0; e < ENT; e++) begin
            if (vld[e] && line[e] == lk_line && !(draining && E_W'(e) == drain_ent)) begin
                lk_match = 1'b1;
                m_idx    = E_W'(e);
            end
            if (!vld[e] && !free_ok) begin
                free_ok = 1'b1;
                f_idx   = E_W'(e);
            end
            if (vld[e] && line[e] == fill_line && !(draining && E_W'(e) == drain_ent)) begin
                fm     = 1'b1;
                fm_idx = E_W'(e);
            end
        end
        lk_can_merge = lk_match && (int'(cnt[m_idx]) < MERGE);
    end

    assign fill_ready = !draining;
    assign rel_valid  = draining;
    assign rel_id     = ids[drain_ent][pos];

    // Allocation, merging, fill capture and in-order release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENT; e++) begin
                vld[e] <= 1'b0;
                cnt[e] <= '0;
            end
            draining  <= 1'b0;
            drain_ent <= '0;
            pos       <= '0;
        end else begin
            if (alloc_en) begin
                vld[f_idx]    <= 1'b1;
                line[f_idx]   <= lk_line;
                cnt[f_idx]    <= CNT_W'(1);
                ids[f_idx][0] <= req_id;
            end
            if (merge_en) begin
                ids[m_idx][cnt[m_idx][POS_W-1:0]] <= req_id;
                cnt[m_idx] <= cnt[m_idx] + CNT_W'(1);
            end
            if (draining) begin
                if (CNT_W'(pos) + CNT_W'(1) >= cnt[drain_ent]) begin
                    draining        <= 1'b0;
                    vld[drain_ent]  <= 1'b0;
                end else begin
                    pos <= pos + POS_W'(1);
                end
            end else if (fill_en && fm) begin
                draining  <= 1'b1;
                drain_ent <= fm_idx;
                pos       <= '0;
            end
        end
    end

    // Fills arrive only while the table can take them.
    assert_fill_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> fill_ready);

    // A merge is only requested into an entry with a free slot.
    assert_merge_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |-> lk_can_merge);

    // A release always comes from a live entry.
    assert_rel_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> vld[drain_ent]);

endmodule

// File: rtl/wtwe_missq.sv
// Outgoing request FIFO with two push slots per cycle (slot 0 enters first)
// and one valid/ready pop port toward memory.
// Assumes: the producer checks count before pushing.
module wtwe_missq #(
    parameter int DEPTH = 4,
    parameter int W     = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push0,
    input  logic [W-1:0]               d0,
    input  logic                       push1,
    input  logic [W-1:0]               d1,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [W-1:0]               out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd, wr, wr1;
    logic             pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    assign pop       = out_valid && out_ready;
    assign out_valid = (count != '0);
    assign out_data  = mem[rd];
    assign wr1       = push0 ? nxt(wr) : wr;

    // Storage write for up to two entries in order.
    always_ff @(posedge clk) begin
        if (push0) mem[wr]  <= d0;
        if (push1) mem[wr1] <= d1;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd    <= '0;
            wr    <= '0;
            count <= '0;
        end else begin
            wr    <= push1 ? nxt(wr1) : wr1;
            if (pop) rd <= nxt(rd);
            count <= count + CNT_W'(push0) + CNT_W'(push1) - CNT_W'(pop);
        end
    end

    // Pushes never exceed the space left after this cycle's pop.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) + int'(push0) + int'(push1)) <= (DEPTH + int'(pop)));

    // The head holds still while memory stalls.
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/wtwe_dcache.sv
// Write-through write-evict cache controller. Decides, per request and in the
// same cycle, the status, the event strobes, the tag update and the miss
// queue pushes. Global write hits evict and forward; local and writeback-class
// write hits mark the line dirty; write misses forward without allocating;
// read misses reserve a way and may push a dirty writeback after the read.
// Assumes: a global write never targets a MODIFIED line.
module wtwe_dcache
    import wtwe_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 4,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int MQ_DEPTH   = 4,
    parameter int MSHR_ENT   = 2,
    parameter int MSHR_MERGE = 3,
    parameter int ID_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic [1:0]              req_class,
    input  logic [ID_W-1:0]         req_id,
    output logic [1:0]              resp_status,
    output logic                    ev_read_sent,
    output logic                    ev_write_sent,
    output logic                    ev_wb_sent,
    output logic                    mq_valid,
    input  logic                    mq_ready,
    output logic [ADDR_W-1:0]       mq_addr,
    output logic [1:0]              mq_kind,
    output logic                    mq_full_line,
    output logic [ID_W-1:0]         mq_id,
    input  logic                    fill_valid,
    input  logic [ADDR_W-OFF_W-1:0] fill_line,
    output logic                    fill_ready,
    output logic                    rel_valid,
    output logic [ID_W-1:0]         rel_id
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int TAG_W  = LINE_W - IDX_W;
    localparam int PAY_W  = 2 + 1 + ID_W + ADDR_W;
    localparam int CNT_W  = $clog2(MQ_DEPTH + 1);

    cls_e              cls;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [LINE_W-1:0] line_a;

    logic              lk_hit, vic_ok;
    logic [WAY_W-1:0]  lk_way, vic_way, op_way;
    line_e             lk_state, vic_state;
    logic [TAG_W-1:0]  vic_tag;
    tagop_e            op;

    logic              lk_match, lk_can_merge, free_ok, alloc_en, merge_en;
    logic              push0, push1;
    logic [PAY_W-1:0]  d0, d1, head;
    logic [CNT_W-1:0]  mq_count;
    logic              has1, has2, usable, rsv, fill_go;
    rsp_e              st;

    assign cls     = cls_e'(req_class);
    assign idx     = req_addr[OFF_W +: IDX_W];
    assign tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign line_a  = req_addr[ADDR_W-1:OFF_W];
    assign usable  = lk_hit && (lk_state == LN_VALID || lk_state == LN_MODIFIED);
    assign rsv     = lk_hit && (lk_state == LN_RESERVED);
    assign has1    = int'(mq_count) < MQ_DEPTH;
    assign has2    = (int'(mq_count) + 1) < MQ_DEPTH;
    assign fill_go = fill_valid && fill_ready;

    // Request policy: status, strobes, tag operation and queue pushes.
    always_comb begin
        st            = ST_HIT;
        ev_read_sent  = 1'b0;
        ev_write_sent = 1'b0;
        ev_wb_sent    = 1'b0;
        op            = OP_NONE;
        op_way        = lk_way;
        alloc_en      = 1'b0;
        merge_en      = 1'b0;
        push0         = 1'b0;
        push1         = 1'b0;
        d0            = {MQ_WR, 1'b0, req_id, req_addr};
        d1            = {MQ_WB, 1'b1, {ID_W{1'b0}}, vic_tag, idx, {OFF_W{1'b0}}};
        if (req_valid) begin
            if (req_write) begin
                if (usable && cls != CL_GWR) begin
                    op = OP_DIRTY;
                end else if (!has1) begin
                    st = ST_FAIL;
                end else begin
                    push0         = 1'b1;
                    ev_write_sent = 1'b1;
                    if (usable) op = OP_INVAL;
                    else        st = ST_MISS;
                end
            end else if (usable) begin
                op = OP_TOUCH;
            end else if (rsv) begin
                if (lk_can_merge) begin
                    st       = ST_HIT_RSV;
                    merge_en = 1'b1;
                end else begin
                    st = ST_FAIL;
                end
            end else if (!has2 || !free_ok || !vic_ok) begin
                st = ST_FAIL;
            end else begin
                st           = ST_MISS;
                op           = OP_RESERVE;
                op_way       = vic_way;
                alloc_en     = 1'b1;
                push0        = 1'b1;
                ev_read_sent = 1'b1;
                d0           = {MQ_RD, 1'b1, req_id, line_a, {OFF_W{1'b0}}};
                if (vic_state == LN_MODIFIED) begin
                    push1      = 1'b1;
                    ev_wb_sent = 1'b1;
                end
            end
        end
    end

    assign resp_status = st;
    assign {mq_kind, mq_full_line, mq_id, mq_addr} = head;

    wtwe_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(idx), .lk_tag(tag),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_state(lk_state),
        .vic_ok(vic_ok), .vic_way(vic_way), .vic_state(vic_state), .vic_tag(vic_tag),
        .op(op), .op_way(op_way),
        .fill_en(fill_go),
        .fill_idx(fill_line[IDX_W-1:0]),
        .fill_tag(fill_line[LINE_W-1 -: TAG_W])
    );

    wtwe_mshr #(.ENT(MSHR_ENT), .MERGE(MSHR_MERGE), .LINE_W(LINE_W), .ID_W(ID_W)) u_mshr (
        .clk(clk), .rst_n(rst_n),
        .lk_line(line_a), .lk_match(lk_match), .lk_can_merge(lk_can_merge),
        .free_ok(free_ok), .alloc_en(alloc_en), .merge_en(merge_en), .req_id(req_id),
        .fill_en(fill_go), .fill_line(fill_line), .fill_ready(fill_ready),
        .rel_valid(rel_valid), .rel_id(rel_id)
    );

    wtwe_missq #(.DEPTH(MQ_DEPTH), .W(PAY_W)) u_mq (
        .clk(clk), .rst_n(rst_n),
        .push0(push0), .d0(d0), .push1(push1), .d1(d1),
        .count(mq_count),
        .out_valid(mq_valid), .out_ready(mq_ready), .out_data(head)
    );

    // A global write must not meet a dirty line.
    assert_gwr_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cls == CL_GWR && lk_hit) |-> (lk_state != LN_MODIFIED));

    // Writebacks only accompany a read miss.
    assert_wb_with_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wb_sent |-> ev_read_sent);

    // A refused request leaves the queue occupancy to memory's pops alone.
    assert_fail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st == ST_FAIL) |=>
        (int'(mq_count) == int'($past(mq_count)) - ($past(mq_valid && mq_ready) ? 1 : 0)));

endmodule

// File: tb/wtwe_dcache_test.sv
`timescale 1ns/100ps
module wtwe_dcache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_class = '0;
    logic [3:0]  req_id = '0;
    logic [1:0]  resp_status;
    logic        ev_read_sent, ev_write_sent, ev_wb_sent;
    logic        mq_valid;
    logic        mq_ready = 1'b0;
    logic [15:0] mq_addr;
    logic [1:0]  mq_kind;
    logic        mq_full_line;
    logic [3:0]  mq_id;
    logic        fill_valid = 1'b0;
    logic [11:0] fill_line = '0;
    logic        fill_ready, rel_valid;
    logic [3:0]  rel_id;

    int total = 0;
    int bad = 0;
    logic [1:0] c_st;
    logic c_rd, c_wr, c_wb;

    always #2.5 clk = ~clk;

    wtwe_dcache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_class(req_class), .req_id(req_id),
        .resp_status(resp_status), .ev_read_sent(ev_read_sent),
        .ev_write_sent(ev_write_sent), .ev_wb_sent(ev_wb_sent),
        .mq_valid(mq_valid), .mq_ready(mq_ready), .mq_addr(mq_addr),
        .mq_kind(mq_kind), .mq_full_line(mq_full_line), .mq_id(mq_id),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_ready(fill_ready),
        .rel_valid(rel_valid), .rel_id(rel_id)
    );

    function automatic logic [15:0] ad(input int t, input int i, input int o);
        return {10'(t), 2'(i), 4'(o)};
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] a, input logic w, input int cl, input int id);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        req_class = 2'(cl); req_id = 4'(id);
        #1;
        c_st = resp_status; c_rd = ev_read_sent; c_wr = ev_write_sent; c_wb = ev_wb_sent;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic resp(input string rq, input int s, input int rd, input int wr, input int wb);
        chk({rq, " status"}, c_st, s);
        chk({rq, " read_sent"}, c_rd, rd);
        chk({rq, " write_sent"}, c_wr, wr);
        chk({rq, " wb_sent"}, c_wb, wb);
    endtask

    task automatic pop_expect(input string rq, input logic [15:0] a, input int k, input int f, input int id);
        @(negedge clk);
        mq_ready = 1'b1;
        #1;
        chk({rq, " mq_valid"}, mq_valid, 1);
        chk({rq, " mq_addr"}, mq_addr, a);
        chk({rq, " mq_kind"}, mq_kind, k);
        chk({rq, " mq_full_line"}, mq_full_line, f);
        chk({rq, " mq_id"}, mq_id, id);
        @(posedge clk); #1;
        mq_ready = 1'b0;
    endtask

    task automatic drain_all();
        for (int n = 0; n < 8; n++) begin
            @(negedge clk); #1;
            if (!mq_valid) break;
            mq_ready = 1'b1;
            @(posedge clk); #1;
            mq_ready = 1'b0;
        end
    endtask

    task automatic fill_rel(input string rq, input logic [15:0] a, input int n,
                            input int i0, input int i1, input int i2);
        int exp_ids [3];
        exp_ids[0] = i0; exp_ids[1] = i1; exp_ids[2] = i2;
        @(negedge clk);
        fill_valid = 1'b1; fill_line = a[15:4];
        #1;
        chk({rq, " fill_ready before fill"}, fill_ready, 1);
        @(posedge clk); #1;
        fill_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            chk({rq, " rel_valid"}, rel_valid, 1);
            chk({rq, " rel_id order"}, rel_id, exp_ids[k]);
            chk({rq, " fill_ready low"}, fill_ready, 0);
        end
        @(negedge clk); #1;
        chk({rq, " release ends"}, rel_valid, 0);
        chk({rq, " fill_ready back"}, fill_ready, 1);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R13 queue empty after reset", mq_valid, 0);
        chk("R12 fill_ready after reset", fill_ready, 1);
        chk("R12 no release after reset", rel_valid, 0);
    endtask

    task automatic t_merge();
        send(ad(1,0,5), 0, 0, 1); resp("R5 read miss", 2, 1, 0, 0);
        send(ad(1,0,5), 0, 0, 2); resp("R11 merge", 1, 0, 0, 0);
        send(ad(1,0,9), 0, 0, 3); resp("R11 merge", 1, 0, 0, 0);
        send(ad(1,0,5), 0, 0, 4); resp("R9 merge list full", 3, 0, 0, 0);
        pop_expect("R5 line read", ad(1,0,0), 0, 1, 1);
        @(negedge clk); #1;
        chk("R10 nothing queued by merges", mq_valid, 0);
        fill_rel("R12", ad(1,0,0), 3, 1, 2, 3);
        send(ad(1,0,5), 0, 0, 5); resp("R1 read hit", 0, 0, 0, 0);
        chk("R1 no push on hit", mq_valid, 0);
    endtask

    task automatic t_dirty_lru();
        send(ad(1,0,0), 1, 2, 6); resp("R3 local write hit", 0, 0, 0, 0);
        chk("R3 no push", mq_valid, 0);
        send(ad(2,0,0), 0, 0, 7); resp("R5 invalid way first", 2, 1, 0, 0);
        drain_all(); fill_rel("R12", ad(2,0,0), 1, 7, 0, 0);
        send(ad(3,0,0), 0, 0, 8); resp("R6 dirty victim", 2, 1, 0, 1);
        pop_expect("R6 read first", ad(3,0,0), 0, 1, 8);
        pop_expect("R6 writeback second", ad(1,0,0), 2, 1, 0);
        fill_rel("R12", ad(3,0,0), 1, 8, 0, 0);
        send(ad(2,0,0), 0, 0, 9); resp("R7 refresh", 0, 0, 0, 0);
        send(ad(4,0,0), 0, 0, 10); resp("R7 clean victim", 2, 1, 0, 0);
        drain_all(); fill_rel("R12", ad(4,0,0), 1, 10, 0, 0);
        send(ad(3,0,0), 0, 0, 11); resp("R7 LRU way evicted", 2, 1, 0, 0);
        drain_all(); fill_rel("R12", ad(3,0,0), 1, 11, 0, 0);
        send(ad(4,0,0), 0, 0, 12); resp("R7 newer way kept", 0, 0, 0, 0);
    endtask

    task automatic t_global();
        send(ad(4,0,3), 1, 1, 12); resp("R2 global write hit", 0, 0, 1, 0);
        pop_expect("R2 forwarded write", ad(4,0,3), 1, 0, 12);
        send(ad(4,0,0), 0, 0, 13); resp("R2 line evicted", 2, 1, 0, 0);
        drain_all(); fill_rel("R12", ad(4,0,0), 1, 13, 0, 0);
    endtask

    task automatic t_write_miss();
        send(ad(5,1,2), 1, 1, 1); resp("R4 global write miss", 2, 0, 1, 0);
        send(ad(6,1,0), 1, 2, 2); resp("R4 local write miss", 2, 0, 1, 0);
        pop_expect("R4 write through", ad(5,1,2), 1, 0, 1);
        pop_expect("R4 write through", ad(6,1,0), 1, 0, 2);
        send(ad(5,1,0), 0, 0, 3); resp("R4 no allocation", 2, 1, 0, 0);
        drain_all(); fill_rel("R12", ad(5,1,0), 1, 3, 0, 0);
        send(ad(7,1,0), 0, 0, 4); resp("R5 read miss", 2, 1, 0, 0);
        send(ad(7,1,0), 1, 2, 5); resp("R4 write to reserved line", 2, 0, 1, 0);
        send(ad(7,1,0), 0, 0, 6); resp("R4 line still reserved", 1, 0, 0, 0);
        drain_all(); fill_rel("R12", ad(7,1,0), 2, 4, 6, 0);
    endtask

    task automatic t_resfail();
        send(ad(8,2,1), 1, 1, 1); resp("R8 write 1", 2, 0, 1, 0);
        send(ad(9,2,2), 1, 1, 2); resp("R8 write 2", 2, 0, 1, 0);
        send(ad(10,2,3), 1, 1, 3); resp("R8 write 3", 2, 0, 1, 0);
        send(ad(11,3,0), 0, 0, 7); resp("R8 read needs two slots", 3, 0, 0, 0);
        send(ad(12,2,4), 1, 1, 4); resp("R8 last slot write", 2, 0, 1, 0);
        send(ad(13,2,5), 1, 1, 5); resp("R8 write on full queue", 3, 0, 0, 0);
        @(negedge clk); #1;
        chk("R13 head before stall", mq_addr, ad(8,2,1));
        @(negedge clk); #1;
        chk("R13 head held while stalled", mq_addr, ad(8,2,1));
        pop_expect("R13 order", ad(8,2,1), 1, 0, 1);
        pop_expect("R13 order", ad(9,2,2), 1, 0, 2);
        pop_expect("R13 order", ad(10,2,3), 1, 0, 3);
        pop_expect("R13 order", ad(12,2,4), 1, 0, 4);
        @(negedge clk); #1;
        chk("R10 refused requests not queued", mq_valid, 0);
        send(ad(11,3,0), 0, 0, 7); resp("R10 refused read left no state", 2, 1, 0, 0);
        drain_all(); fill_rel("R12", ad(11,3,0), 1, 7, 0, 0);
        send(ad(1,2,0), 0, 0, 1); resp("R9 first entry", 2, 1, 0, 0);
        send(ad(2,2,0), 0, 0, 2); resp("R9 second entry", 2, 1, 0, 0);
        send(ad(3,2,0), 0, 0, 3); resp("R9 no entry or way free", 3, 0, 0, 0);
        drain_all();
        fill_rel("R12", ad(1,2,0), 1, 1, 0, 0);
        fill_rel("R12", ad(2,2,0), 1, 2, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_merge();
        t_dirty_lru();
        t_global();
        t_write_miss();
        t_resfail();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule